// File: doc/BRIEF.md
# Transmit Descriptor Poll Engine

This block is the transmit-side DMA engine of a network controller. Software keeps a ring of 16-byte descriptors in memory, hands a descriptor to the engine by setting its ownership bit, and then rings a doorbell. The engine reads the descriptor and fetches the frame buffer it points at. It streams the buffer out one byte at a time on a valid/ready byte interface. It then writes the status word back with ownership cleared and raises a one-cycle completion pulse.

After each write-back the engine moves straight on to the next descriptor without waiting for another doorbell. The ring has no size register. A wrap flag inside a descriptor sends the engine back to the ring base. A descriptor that software still owns stops the walk, and the engine waits there until the next doorbell. Ring base, enable and doorbell are set through a small register write port. Memory is reached through a single-request word port that holds each request until it is acknowledged.

Top module: `txd_poll_engine`

## Requirements
- R1: After reset the engine issues no memory request, presents no stream byte and holds the completion pulse low.
- R2: A register write to offset 0x0C with bit 6 set is a doorbell that starts a descriptor fetch at the current ring pointer. A write to 0x0C with bit 6 clear has no effect.
- R3: Bit 2 of the control register at offset 0x08 enables the engine. While it is clear, no descriptor fetch begins. A doorbell received while disabled is kept, and fetching starts once the bit is set.
- R4: A descriptor is four 32-bit words. The status word is at offset +0 and the buffer address at +8. The words at +4 and +12 are never read. Every memory request holds its address and direction until it is acknowledged.
- R5: When a fetched status word has bit 31 (ownership) clear, the engine streams nothing and writes nothing back. It keeps its ring pointer and stays idle until the next doorbell.
- R6: The frame length is taken from status bits [15:0]. That many bytes are streamed in increasing address order, starting at the buffer address, which may have any byte alignment. Bytes sit in memory words in little-endian lane order.
- R7: The last-byte flag is raised with the final byte of a descriptor whose status bit 28 (last segment) is set, and at no other time.
- R8: After the last byte the engine writes the status word back to the descriptor with only bit 31 cleared. The completion pulse is high for exactly one cycle, in the cycle after that write is acknowledged.
- R9: After a write-back the next descriptor, 16 bytes further on, is fetched without a new doorbell. If status bit 30 (end of ring) was set, the next fetch is at the ring base instead.
- R10: Writing the ring base (offset 0x00) drops address bits [7:0] and reloads the ring pointer. Writes to the upper base register (offset 0x04) have no effect on any address.
- R11: A descriptor of length zero streams no byte but is still written back and still produces the completion pulse.
- R12: While a byte is offered and not accepted, the byte and its last-byte flag stay unchanged.
- R13: A doorbell that arrives in the same cycle as a status word with ownership clear is not lost. The engine fetches that descriptor again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address (word aligned for all requests) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_tdata | output | 8 | Stream byte |
| tx_tvalid | output | 1 | Stream byte valid |
| tx_tready | input | 1 | Stream sink ready |
| tx_tlast | output | 1 | Final byte of a frame |
| tx_ok | output | 1 | One-cycle descriptor completion pulse |

## Verification
Two functions can fall into the same cycle. One is the latching of a doorbell. The other is the engine's reaction to a status word that software still owns, which sends the engine back to idle. The bench watches the memory port for the status read of a non-owned descriptor. It drives a doorbell write in exactly the cycle the acknowledgement is consumed, and in the same cycle it hands the descriptor to hardware in memory. The case passes only if the frame then goes out with no further doorbell, which shows that the late doorbell was kept rather than swallowed by the return to idle.

// File: rtl/txd_pkg.sv
package txd_pkg;
   // Descriptor status word flag positions (software and hardware agree on these)
   localparam int OWN_BIT = 31;
   localparam int EOR_BIT = 30;
   localparam int FS_BIT  = 29;
   localparam int LS_BIT  = 28;

   // Register field positions
   localparam int EN_BIT   = 2;
   localparam int POLL_BIT = 6;

   // Register byte offsets
   localparam logic [7:0] RA_BASE_LO = 8'h00;
   localparam logic [7:0] RA_BASE_HI = 8'h04;
   localparam logic [7:0] RA_CTRL    = 8'h08;
   localparam logic [7:0] RA_POLL    = 8'h0C;

   // Descriptor geometry
   localparam logic [31:0] BUFA_OFS    = 32'd8;
   localparam logic [31:0] DESC_STRIDE = 32'd16;

   typedef enum logic [2:0] {
      S_IDLE,
      S_STAT,
      S_BUFA,
      S_WORD,
      S_SEND,
      S_BACK
   } txd_state_e;
endpackage

// File: rtl/txd_regs.sv
module txd_regs
   import txd_pkg::*;
#(
   parameter int REG_AW     = 8,
   parameter int ALIGN_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              clr_pend,
   output logic [31:0]       ring_base,
   output logic              base_load,
   output logic              tx_en,
   output logic              poll_pend
);
   // The upper base register (RA_BASE_HI) is decoded by nobody: only 32-bit
   // addressing exists, so writes there land nowhere.
   logic hit_lo, hit_ctrl, hit_poll;
   assign hit_lo   = wr_en && (wr_addr == REG_AW'(RA_BASE_LO));
   assign hit_ctrl = wr_en && (wr_addr == REG_AW'(RA_CTRL));
   assign hit_poll = wr_en && (wr_addr == REG_AW'(RA_POLL)) && wr_data[POLL_BIT];

   logic unused_wdata;
   assign unused_wdata = ^wr_data[ALIGN_BITS-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ring_base <= '0;
         base_load <= 1'b0;
         tx_en     <= 1'b0;
         poll_pend <= 1'b0;
      end else begin
         base_load <= 1'b0;
         if (hit_lo) begin
            ring_base <= {wr_data[31:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            base_load <= 1'b1;
         end
         if (hit_ctrl)
            tx_en <= wr_data[EN_BIT];
         // a new doorbell wins over the clear from the engine
         if (hit_poll)
            poll_pend <= 1'b1;
         else if (clr_pend)
            poll_pend <= 1'b0;
      end
   end

   p_poll_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_poll |=> poll_pend);

   p_enable_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ctrl |=> (tx_en == $past(wr_data[EN_BIT])));
endmodule

// File: rtl/txd_lane.sv
module txd_lane #(
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic [31:0] word,
   input  logic [1:0]  sel,
   output logic [7:0]  lane_byte
);
   generate
      if (BIG_ENDIAN) begin : g_be
         assign lane_byte = word[8*(3-sel) +: 8];
      end else begin : g_le
         assign lane_byte = word[8*sel +: 8];
      end
   endgenerate
endmodule

// File: rtl/txd_core.sv
module txd_core
   import txd_pkg::*;
#(
   parameter int LEN_BITS   = 16,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tx_en,
   input  logic        poll_pend,
   input  logic [31:0] ring_base,
   input  logic        base_load,
   output logic        clr_pend,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata,
   output logic [7:0]  tx_tdata,
   output logic        tx_tvalid,
   input  logic        tx_tready,
   output logic        tx_tlast,
   output logic        tx_ok
);
   generate
      if (LEN_BITS < 1 || LEN_BITS > 28) begin : g_bad_len
         $error("txd_core: LEN_BITS must lie in 1..28 so it stays clear of the flag bits");
      end
   endgenerate

   localparam logic [LEN_BITS-1:0] ONE = LEN_BITS'(1);

   txd_state_e          st_q;
   logic [31:0]         cur_q, stat_q, ptr_q, word_q;
   logic [LEN_BITS-1:0] cnt_q;
   logic                ok_q;
   logic [LEN_BITS-1:0] stat_len;

   assign stat_len = stat_q[LEN_BITS-1:0];
   assign clr_pend = (st_q == S_IDLE) && tx_en && poll_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         cur_q  <= '0;
         stat_q <= '0;
         ptr_q  <= '0;
         word_q <= '0;
         cnt_q  <= '0;
         ok_q   <= 1'b0;
      end else begin
         ok_q <= 1'b0;
         case (st_q)
            S_IDLE: if (tx_en && poll_pend) st_q <= S_STAT;
            S_STAT: if (mem_ack) begin
               stat_q <= mem_rdata;
               st_q   <= mem_rdata[OWN_BIT] ? S_BUFA : S_IDLE;
            end
            S_BUFA: if (mem_ack) begin
               ptr_q <= mem_rdata;
               cnt_q <= stat_len;
               st_q  <= (stat_len == '0) ? S_BACK : S_WORD;
            end
            S_WORD: if (mem_ack) begin
               word_q <= mem_rdata;
               st_q   <= S_SEND;
            end
            S_SEND: if (tx_tready) begin
               ptr_q <= ptr_q + 32'd1;
               cnt_q <= cnt_q - ONE;
               if (cnt_q == ONE)
                  st_q <= S_BACK;
               else if (ptr_q[1:0] == 2'b11)
                  st_q <= S_WORD;
            end
            S_BACK: if (mem_ack) begin
               ok_q  <= 1'b1;
               cur_q <= stat_q[EOR_BIT] ? ring_base : (cur_q + DESC_STRIDE);
               st_q  <= tx_en ? S_STAT : S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
         if (base_load)
            cur_q <= ring_base;
      end
   end

   always_comb begin
      mem_req = (st_q == S_STAT) || (st_q == S_BUFA) || (st_q == S_WORD) || (st_q == S_BACK);
      mem_we  = (st_q == S_BACK);
      case (st_q)
         S_BUFA:  mem_addr = cur_q + BUFA_OFS;
         S_WORD:  mem_addr = {ptr_q[31:2], 2'b00};
         default: mem_addr = cur_q;
      endcase
   end

   assign mem_wdata = stat_q & ~(32'h1 << OWN_BIT);

   txd_lane #(.BIG_ENDIAN(BIG_ENDIAN)) u_lane (
      .word      (word_q),
      .sel       (ptr_q[1:0]),
      .lane_byte (tx_tdata)
   );

   assign tx_tvalid = (st_q == S_SEND);
   assign tx_tlast  = (st_q == S_SEND) && (cnt_q == ONE) && stat_q[LS_BIT];
   assign tx_ok     = ok_q;

   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   p_stream_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_tvalid && !tx_tready) |=> (tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast)));

   p_disabled_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == S_IDLE) && !tx_en) |=> (st_q == S_IDLE));

   p_pulse_after_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ok |-> $past(mem_req && mem_we && mem_ack));

   p_not_owned_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == S_STAT) && mem_ack && !mem_rdata[OWN_BIT]) |=> (st_q == S_IDLE));
endmodule

// File: rtl/txd_poll_engine.sv
module txd_poll_engine
   import txd_pkg::*;
#(
   parameter int REG_AW     = 8,
   parameter int ALIGN_BITS = 8,
   parameter int LEN_BITS   = 16,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [31:0]       mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic [7:0]        tx_tdata,
   output logic              tx_tvalid,
   input  logic              tx_tready,
   output logic              tx_tlast,
   output logic              tx_ok
);
   generate
      if (ALIGN_BITS < 4 || ALIGN_BITS > 16) begin : g_bad_align
         $error("txd_poll_engine: ALIGN_BITS must lie in 4..16");
      end
      if (REG_AW < 4 || REG_AW > 8) begin : g_bad_aw
         $error("txd_poll_engine: REG_AW must lie in 4..8");
      end
   endgenerate

   logic [31:0] ring_base;
   logic        base_load, tx_en, poll_pend, clr_pend;

   txd_regs #(.REG_AW(REG_AW), .ALIGN_BITS(ALIGN_BITS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .wr_addr   (reg_addr),
      .wr_data   (reg_wdata),
      .clr_pend  (clr_pend),
      .ring_base (ring_base),
      .base_load (base_load),
      .tx_en     (tx_en),
      .poll_pend (poll_pend)
   );

   txd_core #(.LEN_BITS(LEN_BITS), .BIG_ENDIAN(BIG_ENDIAN)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .poll_pend (poll_pend),
      .ring_base (ring_base),
      .base_load (base_load),
      .clr_pend  (clr_pend),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .tx_tdata  (tx_tdata),
      .tx_tvalid (tx_tvalid),
      .tx_tready (tx_tready),
      .tx_tlast  (tx_tlast),
      .tx_ok     (tx_ok)
   );
endmodule

// File: tb/txd_poll_engine_tb.sv
module txd_poll_engine_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;
   localparam logic [31:0] RB = 32'h0000_0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [7:0]  tx_tdata;
   logic        tx_tvalid, tx_tready, tx_tlast, tx_ok;

   always #(CLK_PERIOD/2) clk = ~clk;

   txd_poll_engine u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .tx_tdata(tx_tdata), .tx_tvalid(tx_tvalid), .tx_tready(tx_tready),
      .tx_tlast(tx_tlast), .tx_ok(tx_ok)
   );

   function automatic logic [7:0] exp_byte(input logic [31:0] a);
      return 8'(a * 5 + (a >> 8) * 3 + 32'h3C);
   endfunction

   function automatic logic [31:0] mk_st(input bit own, input bit eor, input bit fs,
                                         input bit ls, input int len);
      return {own, eor, fs, ls, 12'h000, 16'(len)};
   endfunction

   // memory model: one word per request, acknowledged the cycle after it is seen
   logic [31:0] mem [0:1023];
   logic        bk_we = 1'b0;
   logic [31:0] bk_addr = '0, bk_data = '0;
   int ok_cnt = 0, cap_n = 0, wb_cnt = 0, rd_cnt = 0, bad_rd = 0, dbl_ok = 0;
   logic [7:0] cap_data [0:255];
   logic       cap_last [0:255];
   logic       ok_prev = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         mem_rdata <= '0;
         for (int i = 0; i < 1024; i++)
            mem[i] <= (i >= 64 && i < 128) ? 32'h0 :
                      {exp_byte(4*i+3), exp_byte(4*i+2), exp_byte(4*i+1), exp_byte(4*i)};
      end else begin
         mem_ack <= 1'b0;
         if (bk_we) mem[bk_addr[11:2]] <= bk_data;
         if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
               mem[mem_addr[11:2]] <= mem_wdata;
               wb_cnt <= wb_cnt + 1;
            end else begin
               mem_rdata <= mem[mem_addr[11:2]];
               rd_cnt <= rd_cnt + 1;
               if (mem_addr >= 32'h100 && mem_addr < 32'h200 &&
                   (mem_addr[3:0] == 4'h4 || mem_addr[3:0] == 4'hC))
                  bad_rd <= bad_rd + 1;
            end
         end
         if (tx_tvalid && tx_tready) begin
            cap_data[cap_n[7:0]] <= tx_tdata;
            cap_last[cap_n[7:0]] <= tx_tlast;
            cap_n <= cap_n + 1;
         end
         ok_prev <= tx_ok;
         if (tx_ok) ok_cnt <= ok_cnt + 1;
         if (tx_ok && ok_prev) dbl_ok <= dbl_ok + 1;
      end
   end

   // sink readiness: always ready, or a stalling pattern
   bit bp_mode = 1'b0;
   logic [3:0] lfsr = 4'h9;
   always @(negedge clk) begin
      lfsr <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
      tx_tready <= bp_mode ? lfsr[0] : 1'b1;
   end

   int n_tests = 0, n_fail = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic poke(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      bk_we = 1'b1; bk_addr = a; bk_data = d;
      @(negedge clk);
      bk_we = 1'b0;
   endtask

   task automatic set_desc(input int idx, input logic [31:0] st, input logic [31:0] bufa);
      logic [31:0] d = RB + 32'(16 * idx);
      poke(d, st);
      poke(d + 4, 32'hA5A5_0000 | 32'(idx));
      poke(d + 8, bufa);
      poke(d + 12, 32'h5A5A_0000);
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_ok(input int target, input string tag);
      int g = 0;
      while (ok_cnt < target && g < 3000) begin @(negedge clk); g++; end
      chk(ok_cnt >= target, tag, 32'(ok_cnt), 32'(target));
      settle(20);
   endtask

   task automatic chk_frame(input int from, input int n, input logic [31:0] bufa,
                            input bit last_end, input string tag);
      for (int k = 0; k < n; k++) begin
         chk(cap_data[8'(from + k)] == exp_byte(bufa + 32'(k)), {tag, " byte"},
             32'(cap_data[8'(from + k)]), 32'(exp_byte(bufa + 32'(k))));
         chk(cap_last[8'(from + k)] == (last_end && k == n - 1), {tag, " last flag"},
             32'(cap_last[8'(from + k)]), 32'(last_end && k == n - 1));
      end
   endtask

   // R1
   task automatic t_reset();
      chk(mem_req == 1'b0, "R1 no request after reset", 32'(mem_req), 0);
      chk(tx_tvalid == 1'b0, "R1 no stream after reset", 32'(tx_tvalid), 0);
      chk(tx_ok == 1'b0, "R1 no pulse after reset", 32'(tx_ok), 0);
   endtask

   // R6 R7 R8 R10 R4: single descriptor, unaligned buffer, misaligned base written
   task automatic t_single();
      int c0 = cap_n, o0 = ok_cnt;
      logic [31:0] st = mk_st(1, 0, 1, 1, 5);
      set_desc(0, st, 32'h403);
      wreg(RA_LO, 32'h0000_01A5);
      wreg(RA_HI, 32'hFFFF_FFFF);
      wreg(RA_CT, 32'h4);
      wreg(RA_PL, 32'h40);
      wait_ok(o0 + 1, "R8 completion of single frame");
      chk(cap_n - c0 == 5, "R6 byte count", 32'(cap_n - c0), 5);
      chk_frame(c0, 5, 32'h403, 1, "R6 R7 R10 single");
      chk(mem[RB[11:2]] == (st & 32'h7FFF_FFFF), "R8 status write-back", mem[RB[11:2]], st & 32'h7FFF_FFFF);
      chk(ok_cnt - o0 == 1 && dbl_ok == 0, "R8 single pulse", 32'(ok_cnt - o0), 1);
      chk(mem_req == 1'b0, "R5 idle at non-owned next descriptor", 32'(mem_req), 0);
      chk(bad_rd == 0, "R4 VLAN and high words never read", 32'(bad_rd), 0);
   endtask

   // R7 R9 R12: two-segment frame under back-pressure
   task automatic t_multi();
      int c0 = cap_n, o0 = ok_cnt;
      bp_mode = 1'b1;
      set_desc(1, mk_st(1, 0, 1, 0, 3), 32'h500);
      set_desc(2, mk_st(1, 0, 0, 1, 4), 32'h602);
      wreg(RA_PL, 32'h40);
      wait_ok(o0 + 2, "R9 both segments completed");
      chk(cap_n - c0 == 7, "R12 bytes under stalls", 32'(cap_n - c0), 7);
      chk_frame(c0, 3, 32'h500, 0, "R7 first segment");
      chk_frame(c0 + 3, 4, 32'h602, 1, "R7 R12 last segment");
      bp_mode = 1'b0;
   endtask

   // R9: end-of-ring flag returns to base
   task automatic t_wrap();
      int c0 = cap_n, o0 = ok_cnt;
      bp_mode = 1'b1;
      set_desc(3, mk_st(1, 1, 1, 1, 2), 32'h700);
      set_desc(0, mk_st(1, 0, 1, 1, 1), 32'h710);
      wreg(RA_PL, 32'h40);
      wait_ok(o0 + 2, "R9 wrap completions");
      chk(cap_n - c0 == 3, "R9 byte count across wrap", 32'(cap_n - c0), 3);
      chk_frame(c0, 2, 32'h700, 1, "R9 ring end");
      chk_frame(c0 + 2, 1, 32'h710, 1, "R9 ring base after wrap");
      chk(mem[(RB + 48) >> 2] == mk_st(0, 1, 1, 1, 2), "R8 wb keeps end flag",
          mem[(RB + 48) >> 2], mk_st(0, 1, 1, 1, 2));
      bp_mode = 1'b0;
   endtask

   // R5: not-owned descriptor stalls until next doorbell
   task automatic t_not_owned();
      int c0 = cap_n, o0 = ok_cnt, w0 = wb_cnt;
      wreg(RA_PL, 32'h40);
      settle(30);
      chk(cap_n == c0 && wb_cnt == w0, "R5 nothing sent for software-owned", 32'(cap_n - c0), 0);
      poke(RB + 16, mk_st(1, 0, 1, 1, 3));
      poke(RB + 24, 32'h520);
      settle(30);
      chk(cap_n == c0 && ok_cnt == o0, "R5 no advance without doorbell", 32'(cap_n - c0), 0);
      wreg(RA_PL, 32'h40);
      wait_ok(o0 + 1, "R5 sent after next doorbell");
      chk(cap_n - c0 == 3, "R5 byte count", 32'(cap_n - c0), 3);
      chk_frame(c0, 3, 32'h520, 1, "R5 frame");
   endtask

   // R3: enable gates fetching, doorbell is kept
   task automatic t_disable();
      int c0 = cap_n, o0 = ok_cnt, r0;
      wreg(RA_CT, 32'h0);
      set_desc(2, mk_st(1, 0, 1, 1, 2), 32'h540);
      r0 = rd_cnt;
      wreg(RA_PL, 32'h40);
      settle(40);
      chk(rd_cnt == r0 && mem_req == 1'b0, "R3 no fetch while disabled", 32'(rd_cnt - r0), 0);
      wreg(RA_CT, 32'h4);
      wait_ok(o0 + 1, "R3 kept doorbell acts on enable");
      chk(cap_n - c0 == 2, "R3 byte count", 32'(cap_n - c0), 2);
      chk_frame(c0, 2, 32'h540, 1, "R3 frame");
   endtask

   // R11: zero length
   task automatic t_zero();
      int c0 = cap_n, o0 = ok_cnt;
      set_desc(3, mk_st(1, 1, 1, 1, 0), 32'h560);
      wreg(RA_PL, 32'h40);
      wait_ok(o0 + 1, "R11 pulse for empty descriptor");
      chk(cap_n == c0, "R11 no bytes", 32'(cap_n - c0), 0);
      chk(mem[(RB + 48) >> 2] == mk_st(0, 1, 1, 1, 0), "R11 write-back",
          mem[(RB + 48) >> 2], mk_st(0, 1, 1, 1, 0));
   endtask

   // R2: doorbell without bit 6 is ignored
   task automatic t_poll_bit();
      int c0 = cap_n, o0 = ok_cnt, r0 = rd_cnt;
      set_desc(0, mk_st(1, 0, 1, 1, 1), 32'h580);
      wreg(RA_PL, 32'hFFFF_FFBF);
      settle(30);
      chk(rd_cnt == r0 && cap_n == c0, "R2 write without poll bit ignored", 32'(rd_cnt - r0), 0);
      wreg(RA_PL, 32'h40);
      wait_ok(o0 + 1, "R2 doorbell starts fetch");
      chk_frame(c0, 1, 32'h580, 1, "R2 frame");
   endtask

   // R13: doorbell in the cycle a non-owned status is consumed
   task automatic t_collide();
      int c0 = cap_n, o0 = ok_cnt, g = 0;
      wreg(RA_PL, 32'h40);
      while (!(mem_req && !mem_we && mem_addr == RB + 16 && !mem_ack) && g < 200) begin
         @(negedge clk); g++;
      end
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = RA_PL; reg_wdata = 32'h40;
      bk_we = 1'b1; bk_addr = RB + 16; bk_data = mk_st(1, 0, 1, 1, 4);
      @(negedge clk);
      reg_wr_en = 1'b0; bk_we = 1'b0;
      wait_ok(o0 + 1, "R13 doorbell not lost");
      chk(cap_n - c0 == 4, "R13 byte count", 32'(cap_n - c0), 4);
      chk_frame(c0, 4, 32'h520, 1, "R13 frame");
   endtask

   localparam logic [7:0] RA_LO = 8'h00, RA_HI = 8'h04, RA_CT = 8'h08, RA_PL = 8'h0C;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_multi();
      t_wrap();
      t_not_owned();
      t_disable();
      t_zero();
      t_poll_bit();
      t_collide();
      chk(dbl_ok == 0, "R8 pulse never longer than one cycle", 32'(dbl_ok), 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
      $finish;
   end
endmodule